// File: doc/BRIEF.md
# Validated Manual Reference Clock Selector

This block chooses which of four reference clock inputs feeds a downstream PLL while the switching-mode field requests manual operation. The mode field is 3 bits wide. A 0 in its top bit means manual mode, and the two lower bits then name the requested input. A clock monitor outside this block supplies one valid flag per input, synchronous to the control clock.

The requested input is adopted only while its valid flag is high. If the flag is low, the current choice stays in place. The request remains pending, and the block adopts it on the first enabled edge at which that input turns valid. A 2-bit status output reports the input actually in use, so software can read it after a request and see whether the switch took place.

When the top mode bit is 1, the block holds its last choice and ignores the lower bits. A clock enable gates every update. The reset is asynchronous and active low. Its assertion takes effect at once, and its release is synchronised inside the block.

Top module: `refsel_manual`

## Requirements
- R1: While rst_n is low, sel_idx and sel_stat are both 0 (input 0), without waiting for a clock edge.
- R2: On an enabled edge where mode[2] is 0 and valid[mode[1:0]] is 1, sel_idx takes the value mode[1:0], seen right after that edge.
- R3: On an enabled edge where mode[2] is 0 and valid[mode[1:0]] is 0, sel_idx keeps its value.
- R4: A manual request that is held while its target is invalid is carried out on the first enabled edge at which the target becomes valid.
- R5: On an enabled edge where mode[2] is 1, sel_idx keeps its value whatever mode[1:0] and the valid flags are.
- R6: On an edge where clk_en is 0, sel_idx keeps its value.
- R7: sel_stat always equals sel_idx, using the same encoding (0 to 3 = input index).
- R8: If the selected input's own valid flag drops while the request still names that input, the selection is kept: there is no automatic failover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Update enable |
| mode | input | 3 | Switching-mode field; bit 2 = 0 means manual, bits 1:0 give the requested input |
| in_valid | input | 4 | Per-input valid flags from the clock monitor |
| sel_idx | output | 2 | Index of the reference in use |
| sel_stat | output | 2 | Selection status for software |

## Verification
A wrong selection register shows on both index outputs one edge after the request that caused it. Because the state is only two bits wide, every error is visible at the ports at once; none can stay hidden. A gate that ignores the valid flag appears as a switch to an invalid input on the first edge after such a request. A missing enable or mode check shows as a change on an edge that should have held. A broken reset shows before the first edge.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned NUM_REFS = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_REFS);
  localparam int unsigned MODE_W   = IDX_W + 1;

  typedef logic [IDX_W-1:0] ref_idx_t;

  typedef struct packed {
    logic     automatic_sw;
    ref_idx_t target;
  } mode_t;
endpackage

// File: rtl/refsel_rst_sync.sv
module refsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/refsel_req_gate.sv
module refsel_req_gate
  import refsel_pkg::*;
#(
  parameter int unsigned N = NUM_REFS
) (
  input  logic     clk_en,
  input  mode_t    mode,
  input  logic [N-1:0] in_valid,
  input  ref_idx_t cur_idx,
  output logic     accept,
  output ref_idx_t req_idx
);
  logic [N-1:0] hit;

  // One-hot decode of the requested input, masked by its valid flag.
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = (mode.target == ref_idx_t'(g)) && in_valid[g];
  end

  always_comb begin
    req_idx = mode.target;
    accept  = clk_en && !mode.automatic_sw && (|hit) && (mode.target != cur_idx);
  end
endmodule

// File: rtl/refsel_state.sv
module refsel_state
  import refsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_sync_n,
  input  logic     accept,
  input  ref_idx_t req_idx,
  output ref_idx_t sel_q
);
  ref_idx_t sel_d;

  always_comb begin
    sel_d = sel_q;
    if (accept) sel_d = req_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sel_q <= '0;
    else             sel_q <= sel_d;
  end
endmodule

// File: rtl/refsel_manual.sv
module refsel_manual
  import refsel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en,
  input  logic [MODE_W-1:0]   mode,
  input  logic [NUM_REFS-1:0] in_valid,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [IDX_W-1:0]    sel_stat
);
  logic     rst_sync_n;
  logic     accept;
  ref_idx_t req_idx;
  ref_idx_t sel_q;
  mode_t    mode_s;

  assign mode_s = mode_t'(mode);

  refsel_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  refsel_req_gate #(.N(NUM_REFS)) u_gate (
    .clk_en   (clk_en),
    .mode     (mode_s),
    .in_valid (in_valid),
    .cur_idx  (sel_q),
    .accept   (accept),
    .req_idx  (req_idx)
  );

  refsel_state u_state (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .accept     (accept),
    .req_idx    (req_idx),
    .sel_q      (sel_q)
  );

  assign sel_idx  = sel_q;
  assign sel_stat = sel_q;

  // R2: a valid manual request is adopted on the next edge
  a_r2_valid_switch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && !mode[MODE_W-1] && in_valid[mode[IDX_W-1:0]]) |=> (sel_idx == $past(mode[IDX_W-1:0])));
  // R3: a request for an invalid input leaves the choice alone
  a_r3_hold_invalid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && !mode[MODE_W-1] && !in_valid[mode[IDX_W-1:0]]) |=> $stable(sel_idx));
  // R5: outside manual mode the choice is frozen
  a_r5_hold_automatic: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && mode[MODE_W-1]) |=> $stable(sel_idx));
  // R6: no update without the enable
  a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clk_en |=> $stable(sel_idx));
endmodule

// File: tb/refsel_manual_tb.sv
module refsel_manual_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       clk_en;
  logic [2:0] mode;
  logic [3:0] in_valid;
  logic [1:0] sel_idx;
  logic [1:0] sel_stat;

  int total = 0;
  int bad   = 0;
  logic [1:0] exp_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsel_manual dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .mode     (mode),
    .in_valid (in_valid),
    .sel_idx  (sel_idx),
    .sel_stat (sel_stat)
  );

  function automatic logic [1:0] model_next(logic [1:0] cur, logic en,
                                            logic [2:0] m, logic [3:0] v);
    if (en && !m[2] && v[m[1:0]]) return m[1:0];
    return cur;
  endfunction

  task automatic check(string req, logic [1:0] got, logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Inputs are driven just after a falling edge; outputs are checked at the next falling edge.
  task automatic step(string req, logic en, logic [2:0] m, logic [3:0] v);
    clk_en = en; mode = m; in_valid = v;
    exp_sel = model_next(exp_sel, en, m, v);
    @(negedge clk);
    check(req, sel_idx, exp_sel);
    check("R7", sel_stat, sel_idx);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; clk_en = 1'b1; mode = 3'b011; in_valid = 4'hF;
    exp_sel = 2'd0;
    #1;
    check("R1", sel_idx, 2'd0);
    check("R1", sel_stat, 2'd0);
    repeat (3) @(negedge clk);
    check("R1", sel_idx, 2'd0);
    rst_n = 1'b1;
    mode = 3'b000;
    repeat (4) @(negedge clk);
    check("R1", sel_idx, 2'd0);

    step("R2", 1'b1, 3'b010, 4'b0100);           // to input 2
    step("R3", 1'b1, 3'b001, 4'b0100);           // input 1 invalid, stay 2
    step("R3", 1'b1, 3'b001, 4'b1101);
    step("R4", 1'b1, 3'b001, 4'b0010);           // pending request now valid
    step("R8", 1'b1, 3'b001, 4'b0000);           // selected input drops: keep
    step("R5", 1'b1, 3'b111, 4'b1111);           // auto mode, ignore bits
    step("R5", 1'b1, 3'b100, 4'b1111);
    step("R6", 1'b0, 3'b011, 4'b1111);           // no enable
    step("R2", 1'b1, 3'b011, 4'b1000);           // to input 3
    step("R2", 1'b1, 3'b000, 4'b0001);           // back to 0

    // Asynchronous reset in mid-run
    step("R2", 1'b1, 3'b010, 4'b0100);
    #2 rst_n = 1'b0; #1;
    check("R1", sel_idx, 2'd0);
    check("R1", sel_stat, 2'd0);
    exp_sel = 2'd0;
    @(negedge clk); rst_n = 1'b1; mode = 3'b100;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      logic en;
      logic [2:0] m;
      logic [3:0] v;
      en = ($urandom % 8) != 0;
      m  = 3'($urandom);
      v  = 4'($urandom);
      step("R2", en, m, v);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule